// File: doc/BRIEF.md
# Trap entry controller

This block applies the architectural state update when a core accepts an exception or an interrupt. A request carries a cause word, the PC of the trapping instruction and a trap value. In one clock edge the block decides where the trap goes and commits every side effect. The trap can go to the supervisor handler, to the machine handler (direct or vectored), or into the debug ROM. The block holds the trap registers, the status enable and previous-state bits, the delegation masks, the breakpoint-to-debug enables, the debug capture registers and the current privilege.

On the cycle after each accepted trap, a one-cycle redirect tells fetch where to go. A plain write port loads the configuration state: vectors, delegation masks, status bits, privilege and breakpoint enables. A reservation-set strobe marks an outstanding load reservation, which handler entry clears.

Privilege codes are U = 0, S = 1, M = 3. The top bit of the cause word is the interrupt flag. The lower bits form the cause index. An exception with index 3 is a breakpoint.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `dbg_active` is 1, a trap redirects to `DBG_ENTRY` when it is a breakpoint (interrupt flag 0, index 3) and to `DBG_TVEC` otherwise. No other register, including privilege, the reservation and the capture registers, changes.
- R2: Outside debug mode, a breakpoint enters debug mode when the enable for the current privilege is set. The enables are `dbg_en` bit 0 for M, bit 1 for S and bit 2 for U. Entry sets `dbg_active`, sets `dbg_cause` to 1, records the old privilege in `dbg_prev_priv`, copies the trap PC into `d_pc`, sets privilege to M and redirects to `DBG_ENTRY`.
- R3: A non-debug trap goes to the supervisor handler only when privilege is U or S and the cause index bit is set in the delegation mask. Interrupts use the interrupt mask and exceptions use the exception mask. In every other case the trap goes to the machine handler.
- R4: Supervisor entry redirects to `stvec` and writes `s_cause`, `s_epc` and `s_tval`. It also copies SIE into SPIE, puts the old privilege (U = 0, S = 1) into SPP, clears SIE and sets privilege to S.
- R5: Machine entry writes `m_cause`, `m_epc` and `m_tval`. It also copies MIE into MPIE, puts the old privilege into MPP, clears MIE and sets privilege to M.
- R6: For machine entry, when `mtvec` bit 0 is 1 and the trap is an interrupt, the target is `mtvec` with bit 0 cleared plus four times the cause index. Otherwise the target is `mtvec` with bit 0 cleared.
- R7: `resv_set` marks a reservation outstanding. Supervisor or machine entry clears it. Debug entry and traps taken in debug mode leave it unchanged.
- R8: The interrupt flag is removed before the delegation mask is indexed. A cause index of `XLEN` or more is never delegated.
- R9: `redirect_valid` is 1 for exactly the cycle after each accepted trap, with `redirect_pc` holding the target, and is 0 otherwise.
- R10: Configuration writes take effect at the next edge. The select codes are 0 mtvec (bit 1 forced 0), 1 stvec (bits 1:0 forced 0), 2 exception mask, 3 interrupt mask, 4 status, 5 privilege and 6 breakpoint enables in bits 2:0. Status bits are [0] SIE, [1] MIE, [2] SPIE, [3] MPIE, [4] SPP, [6:5] MPP. A privilege write of 2 is dropped. A write or `resv_set` in the same cycle as a trap is dropped.
- R11: After reset, privilege is M, debug mode is off, redirect is low, and every other register and status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Accept a trap this cycle |
| trap_cause | input | XLEN | Cause word, top bit is the interrupt flag |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | XLEN | Configuration write data |
| resv_set | input | 1 | Mark a load reservation outstanding |
| redirect_valid | output | 1 | Redirect pulse after a trap |
| redirect_pc | output | XLEN | Redirect target |
| cur_priv | output | 2 | Current privilege |
| status | output | 8 | Status bits, layout as in R10 |
| m_epc | output | XLEN | Machine saved PC |
| m_cause | output | XLEN | Machine cause |
| m_tval | output | XLEN | Machine trap value |
| s_epc | output | XLEN | Supervisor saved PC |
| s_cause | output | XLEN | Supervisor cause |
| s_tval | output | XLEN | Supervisor trap value |
| d_pc | output | XLEN | Debug saved PC |
| dbg_active | output | 1 | Debug mode active |
| dbg_cause | output | 3 | Debug entry cause |
| dbg_prev_priv | output | 2 | Privilege before debug entry |
| dbg_en | output | 3 | Breakpoint-to-debug enables |
| resv_valid | output | 1 | Load reservation outstanding |

## Verification
The bench targets several corner cases:
- An interrupt whose index matches the breakpoint code while in debug mode. A design that tests only the index would send it to the debug entry instead of the trap vector.
- An interrupt with the interrupt-mask bit set taken in M. A design that ignores privilege would wrongly drop to S.
- Causes whose index is beyond the mask width. A design that wraps the index would delegate them.
- Vectored exceptions. A design that offsets exceptions by the cause would land past the base.
- Writes and reservation strobes that collide with a trap. A design that lets them through would corrupt freshly saved state.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int unsigned BRK_IDX = 3;
    localparam logic [2:0]  DBG_CAUSE_BRK = 3'd1;

    localparam logic [2:0] SEL_MTVEC  = 3'd0;
    localparam logic [2:0] SEL_STVEC  = 3'd1;
    localparam logic [2:0] SEL_EDELEG = 3'd2;
    localparam logic [2:0] SEL_IDELEG = 3'd3;
    localparam logic [2:0] SEL_STATUS = 3'd4;
    localparam logic [2:0] SEL_PRIV   = 3'd5;
    localparam logic [2:0] SEL_DBGEN  = 3'd6;

    typedef enum logic [1:0] {
        RT_DBG_HOLD,
        RT_DBG_ENTER,
        RT_SUP,
        RT_MACH
    } route_e;
endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause,
    input  logic [1:0]      priv,
    input  logic            in_debug,
    input  logic [2:0]      brk_en,
    input  logic [XLEN-1:0] edeleg,
    input  logic [XLEN-1:0] ideleg,
    output route_e          route,
    output logic            is_irq,
    output logic            is_brk
);
    localparam int IW = $clog2(XLEN);

    logic [XLEN-2:0] idx;
    logic            in_range;
    logic [XLEN-1:0] mask;
    logic            low_priv;
    logic            brk_allowed;
    logic            delegate;

    always_comb begin
        is_irq   = cause[XLEN-1];
        idx      = cause[XLEN-2:0];
        is_brk   = !is_irq && (idx == (XLEN-1)'(BRK_IDX));
        in_range = idx < (XLEN-1)'(XLEN);
        mask     = is_irq ? ideleg : edeleg;
        low_priv = (priv == PRIV_U) || (priv == PRIV_S);
        delegate = low_priv && in_range && mask[idx[IW-1:0]];
        case (priv)
            PRIV_M:  brk_allowed = brk_en[0];
            PRIV_S:  brk_allowed = brk_en[1];
            PRIV_U:  brk_allowed = brk_en[2];
            default: brk_allowed = 1'b0;
        endcase
        if (in_debug)
            route = RT_DBG_HOLD;
        else if (is_brk && brk_allowed)
            route = RT_DBG_ENTER;
        else if (delegate)
            route = RT_SUP;
        else
            route = RT_MACH;
    end
endmodule

// File: rtl/trap_target.sv
module trap_target
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
    parameter logic [XLEN-1:0] DBG_TVEC  = 'h808
) (
    input  route_e          route,
    input  logic            is_irq,
    input  logic            is_brk,
    input  logic [XLEN-1:0] cause,
    input  logic [XLEN-1:0] mtvec,
    input  logic [XLEN-1:0] stvec,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {mtvec[XLEN-1:1], 1'b0};
        offset = (mtvec[0] && is_irq) ? {cause[XLEN-3:0], 2'b00} : '0;
        case (route)
            RT_DBG_HOLD:  target = is_brk ? DBG_ENTRY : DBG_TVEC;
            RT_DBG_ENTER: target = DBG_ENTRY;
            RT_SUP:       target = stvec;
            default:      target = base + offset;
        endcase
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
    parameter logic [XLEN-1:0] DBG_TVEC  = 'h808
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_epc,
    input  logic [XLEN-1:0] trap_tval,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [XLEN-1:0] cfg_wdata,
    input  logic            resv_set,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      cur_priv,
    output logic [7:0]      status,
    output logic [XLEN-1:0] m_epc,
    output logic [XLEN-1:0] m_cause,
    output logic [XLEN-1:0] m_tval,
    output logic [XLEN-1:0] s_epc,
    output logic [XLEN-1:0] s_cause,
    output logic [XLEN-1:0] s_tval,
    output logic [XLEN-1:0] d_pc,
    output logic            dbg_active,
    output logic [2:0]      dbg_cause,
    output logic [1:0]      dbg_prev_priv,
    output logic [2:0]      dbg_en,
    output logic            resv_valid
);
    typedef struct packed {
        logic [1:0]      priv;
        logic            sie;
        logic            mie;
        logic            spie;
        logic            mpie;
        logic            spp;
        logic [1:0]      mpp;
        logic [XLEN-1:0] mtvec;
        logic [XLEN-1:0] stvec;
        logic [XLEN-1:0] edeleg;
        logic [XLEN-1:0] ideleg;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mtval;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] stval;
        logic [XLEN-1:0] dpc;
        logic            dbg;
        logic [2:0]      dcause;
        logic [1:0]      dprv;
        logic [2:0]      brk_en;
        logic            resv;
        logic            rvld;
        logic [XLEN-1:0] rpc;
    } state_t;

    state_t st_d, st_q;

    route_e          route;
    logic            is_irq;
    logic            is_brk;
    logic [XLEN-1:0] tgt_pc;

    trap_route #(.XLEN(XLEN)) u_route (
        .cause    (trap_cause),
        .priv     (st_q.priv),
        .in_debug (st_q.dbg),
        .brk_en   (st_q.brk_en),
        .edeleg   (st_q.edeleg),
        .ideleg   (st_q.ideleg),
        .route    (route),
        .is_irq   (is_irq),
        .is_brk   (is_brk)
    );

    trap_target #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY), .DBG_TVEC(DBG_TVEC)) u_target (
        .route  (route),
        .is_irq (is_irq),
        .is_brk (is_brk),
        .cause  (trap_cause),
        .mtvec  (st_q.mtvec),
        .stvec  (st_q.stvec),
        .target (tgt_pc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rvld = 1'b0;
        if (trap_valid) begin
            st_d.rvld = 1'b1;
            st_d.rpc  = tgt_pc;
            case (route)
                RT_DBG_HOLD: ;
                RT_DBG_ENTER: begin
                    st_d.dbg    = 1'b1;
                    st_d.dcause = DBG_CAUSE_BRK;
                    st_d.dprv   = st_q.priv;
                    st_d.dpc    = trap_epc;
                    st_d.priv   = PRIV_M;
                end
                RT_SUP: begin
                    st_d.scause = trap_cause;
                    st_d.sepc   = trap_epc;
                    st_d.stval  = trap_tval;
                    st_d.spie   = st_q.sie;
                    st_d.spp    = st_q.priv[0];
                    st_d.sie    = 1'b0;
                    st_d.priv   = PRIV_S;
                    st_d.resv   = 1'b0;
                end
                default: begin
                    st_d.mcause = trap_cause;
                    st_d.mepc   = trap_epc;
                    st_d.mtval  = trap_tval;
                    st_d.mpie   = st_q.mie;
                    st_d.mpp    = st_q.priv;
                    st_d.mie    = 1'b0;
                    st_d.priv   = PRIV_M;
                    st_d.resv   = 1'b0;
                end
            endcase
        end else begin
            if (resv_set)
                st_d.resv = 1'b1;
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_MTVEC:  st_d.mtvec  = cfg_wdata & ~(XLEN'(2));
                    SEL_STVEC:  st_d.stvec  = cfg_wdata & ~(XLEN'(3));
                    SEL_EDELEG: st_d.edeleg = cfg_wdata;
                    SEL_IDELEG: st_d.ideleg = cfg_wdata;
                    SEL_STATUS: begin
                        st_d.sie  = cfg_wdata[0];
                        st_d.mie  = cfg_wdata[1];
                        st_d.spie = cfg_wdata[2];
                        st_d.mpie = cfg_wdata[3];
                        st_d.spp  = cfg_wdata[4];
                        st_d.mpp  = cfg_wdata[6:5];
                    end
                    SEL_PRIV: begin
                        if (cfg_wdata[1:0] != 2'd2)
                            st_d.priv = cfg_wdata[1:0];
                    end
                    SEL_DBGEN:  st_d.brk_en = cfg_wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.rvld;
    assign redirect_pc    = st_q.rpc;
    assign cur_priv       = st_q.priv;
    assign status         = {1'b0, st_q.mpp, st_q.spp, st_q.mpie, st_q.spie, st_q.mie, st_q.sie};
    assign m_epc          = st_q.mepc;
    assign m_cause        = st_q.mcause;
    assign m_tval         = st_q.mtval;
    assign s_epc          = st_q.sepc;
    assign s_cause        = st_q.scause;
    assign s_tval         = st_q.stval;
    assign d_pc           = st_q.dpc;
    assign dbg_active     = st_q.dbg;
    assign dbg_cause      = st_q.dcause;
    assign dbg_prev_priv  = st_q.dprv;
    assign dbg_en         = st_q.brk_en;
    assign resv_valid     = st_q.resv;

    p_redirect_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redirect_valid);

    p_debug_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && dbg_active) |=> ($stable(cur_priv) && $stable(m_epc)
                                        && $stable(s_epc) && $stable(resv_valid)));

    p_enable_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !dbg_active) |=> (dbg_active || (cur_priv == PRIV_M && !status[1])
                                         || (cur_priv == PRIV_S && !status[0])));

    p_no_deleg_from_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && cur_priv == PRIV_M) |=> (cur_priv == PRIV_M));

    p_resv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !dbg_active) |=> (!resv_valid || dbg_active));
endmodule

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;
    localparam int XLEN = 32;
    localparam logic [31:0] ENTRY = 32'h800;
    localparam logic [31:0] TVEC  = 32'h808;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_valid = 1'b0;
    logic [31:0] trap_cause = '0, trap_epc = '0, trap_tval = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic resv_set = 1'b0;
    logic redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0] cur_priv;
    logic [7:0] status;
    logic [31:0] m_epc, m_cause, m_tval, s_epc, s_cause, s_tval, d_pc;
    logic dbg_active;
    logic [2:0] dbg_cause;
    logic [1:0] dbg_prev_priv;
    logic [2:0] dbg_en;
    logic resv_valid;

    always #2.5 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .DBG_ENTRY(ENTRY), .DBG_TVEC(TVEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_epc(trap_epc), .trap_tval(trap_tval), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .resv_set(resv_set), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .cur_priv(cur_priv), .status(status), .m_epc(m_epc),
        .m_cause(m_cause), .m_tval(m_tval), .s_epc(s_epc), .s_cause(s_cause),
        .s_tval(s_tval), .d_pc(d_pc), .dbg_active(dbg_active), .dbg_cause(dbg_cause),
        .dbg_prev_priv(dbg_prev_priv), .dbg_en(dbg_en), .resv_valid(resv_valid)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0]  e_priv;
    logic        e_sie, e_mie, e_spie, e_mpie, e_spp;
    logic [1:0]  e_mpp;
    logic [31:0] e_mtvec, e_stvec, e_edeleg, e_ideleg;
    logic [31:0] e_mepc, e_mcause, e_mtval, e_sepc, e_scause, e_stval, e_dpc;
    logic        e_dbg;
    logic [2:0]  e_dcause, e_brk;
    logic [1:0]  e_dprv;
    logic        e_resv, e_rv;
    logic [31:0] e_rpc;
    string       tag;

    task automatic chk(input string t, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", t, what, got, exp);
        end
    endtask

    function automatic logic [7:0] e_status();
        return {1'b0, e_mpp, e_spp, e_mpie, e_spie, e_mie, e_sie};
    endfunction

    task automatic model_reset();
        e_priv = 2'd3; {e_sie, e_mie, e_spie, e_mpie, e_spp} = '0; e_mpp = '0;
        e_mtvec = '0; e_stvec = '0; e_edeleg = '0; e_ideleg = '0;
        e_mepc = '0; e_mcause = '0; e_mtval = '0; e_sepc = '0; e_scause = '0; e_stval = '0;
        e_dpc = '0; e_dbg = 0; e_dcause = '0; e_brk = '0; e_dprv = '0;
        e_resv = 0; e_rv = 0; e_rpc = '0;
    endtask

    task automatic model_trap(input logic [31:0] c, input logic [31:0] pc, input logic [31:0] tv);
        logic irq, brk, en, dl;
        logic [30:0] idx;
        logic [31:0] mask, base;
        irq = c[31]; idx = c[30:0]; brk = !irq && idx == 31'd3;
        e_rv = 1;
        if (e_dbg) begin
            e_rpc = brk ? ENTRY : TVEC; tag = "R1";
        end else begin
            en = (e_priv == 2'd3) ? e_brk[0] : (e_priv == 2'd1) ? e_brk[1] :
                 (e_priv == 2'd0) ? e_brk[2] : 1'b0;
            if (brk && en) begin
                e_dbg = 1; e_dcause = 3'd1; e_dprv = e_priv; e_dpc = pc; e_priv = 2'd3;
                e_rpc = ENTRY; tag = "R2";
            end else begin
                mask = irq ? e_ideleg : e_edeleg;
                dl = (e_priv <= 2'd1) && (idx < 31'd32) && mask[idx[4:0]];
                if (dl) begin
                    e_scause = c; e_sepc = pc; e_stval = tv; e_spie = e_sie;
                    e_spp = e_priv[0]; e_sie = 0; e_priv = 2'd1; e_rpc = e_stvec; tag = "R4";
                end else begin
                    e_mcause = c; e_mepc = pc; e_mtval = tv; e_mpie = e_mie;
                    e_mpp = e_priv; e_mie = 0; e_priv = 2'd3;
                    base = {e_mtvec[31:1], 1'b0};
                    e_rpc = (e_mtvec[0] && irq) ? base + {idx[29:0], 2'b00} : base;
                    tag = (e_mtvec[0] && irq) ? "R6" : "R5";
                end
                e_resv = 0;
            end
        end
    endtask

    task automatic model_cfg(input logic [2:0] s, input logic [31:0] d);
        case (s)
            3'd0: e_mtvec = d & ~32'd2;
            3'd1: e_stvec = d & ~32'd3;
            3'd2: e_edeleg = d;
            3'd3: e_ideleg = d;
            3'd4: {e_mpp, e_spp, e_mpie, e_spie, e_mie, e_sie} = d[6:0];
            3'd5: if (d[1:0] != 2'd2) e_priv = d[1:0];
            3'd6: e_brk = d[2:0];
            default: ;
        endcase
    endtask

    task automatic check_all(input string t);
        chk("R9", "redirect_valid", {31'd0, redirect_valid}, {31'd0, e_rv});
        if (e_rv) chk("R9", "redirect_pc", redirect_pc, e_rpc);
        chk((t == "R1" || t == "R10") ? t : "R3", "priv", {30'd0, cur_priv}, {30'd0, e_priv});
        chk(t, "status", {24'd0, status}, {24'd0, e_status()});
        chk(t, "m_epc", m_epc, e_mepc);
        chk(t, "m_cause", m_cause, e_mcause);
        chk(t, "m_tval", m_tval, e_mtval);
        chk(t, "s_epc", s_epc, e_sepc);
        chk(t, "s_cause", s_cause, e_scause);
        chk(t, "s_tval", s_tval, e_stval);
        chk(t, "d_pc", d_pc, e_dpc);
        chk(t, "dbg_active", {31'd0, dbg_active}, {31'd0, e_dbg});
        chk(t, "dbg_cause", {29'd0, dbg_cause}, {29'd0, e_dcause});
        chk(t, "dbg_prev_priv", {30'd0, dbg_prev_priv}, {30'd0, e_dprv});
        chk(t, "dbg_en", {29'd0, dbg_en}, {29'd0, e_brk});
        chk((t == "R1" || t == "R2") ? t : "R7", "resv_valid", {31'd0, resv_valid}, {31'd0, e_resv});
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
        check_all("R11");
    endtask

    // Trap with optional colliding write and reservation strobe (dropped, R10)
    task automatic do_trap(input logic [31:0] c, input logic [31:0] pc, input logic [31:0] tv,
                           input bit collide, input string tag_in);
        trap_valid = 1; trap_cause = c; trap_epc = pc; trap_tval = tv;
        cfg_we = collide; cfg_sel = 3'($urandom % 7); cfg_wdata = $urandom;
        resv_set = collide;
        @(negedge clk);
        trap_valid = 0; cfg_we = 0; resv_set = 0;
        model_trap(c, pc, tv);
        if (tag_in != "") tag = tag_in;
        check_all(tag);
    endtask

    task automatic do_cfg(input logic [2:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        model_cfg(s, d); e_rv = 0;
        check_all("R10");
    endtask

    task automatic do_resv();
        resv_set = 1;
        @(negedge clk);
        resv_set = 0;
        e_resv = 1; e_rv = 0;
        check_all("R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R6: vectored interrupt, index 7
        do_cfg(3'd0, 32'h1000_0001);
        do_cfg(3'd4, 32'h0000_0002);
        do_trap(32'h8000_0007, 32'h100, 32'h0, 0, "R6");
        chk("R6", "vectored pc", redirect_pc, 32'h1000_001C);
        // R6: exception with vectored mode goes to base
        do_trap(32'h0000_0005, 32'h104, 32'h55, 0, "R6");
        chk("R6", "exception base", redirect_pc, 32'h1000_0000);
        // R3: interrupt delegated in mask but taken in M stays in M
        do_cfg(3'd3, 32'hFFFF_FFFF);
        do_trap(32'h8000_0001, 32'h108, 32'h0, 0, "R3");
        chk("R3", "stays M", {30'd0, cur_priv}, 32'd3);
        // R4: delegated exception from U
        do_cfg(3'd1, 32'h2000_0007);
        do_cfg(3'd2, 32'h0000_0100);
        do_cfg(3'd4, 32'h0000_0001);
        do_cfg(3'd5, 32'd0);
        do_resv();
        do_trap(32'h0000_0008, 32'h200, 32'h12, 0, "R4");
        chk("R4", "stvec target", redirect_pc, 32'h2000_0004);
        chk("R4", "spie from sie", {31'd0, status[2]}, 32'd1);
        // R8: huge index from S with full mask goes to M
        do_cfg(3'd2, 32'hFFFF_FFFF);
        do_trap(32'h0000_0028, 32'h300, 32'h0, 0, "R8");
        chk("R8", "no deleg out of range", {30'd0, cur_priv}, 32'd3);
        // R10: privilege code 2 dropped
        do_cfg(3'd5, 32'd2);
        // R2: breakpoint from U with U enable
        do_cfg(3'd5, 32'd0);
        do_cfg(3'd6, 32'd4);
        do_trap(32'h0000_0003, 32'h400, 32'h0, 0, "R2");
        chk("R2", "debug entry", {31'd0, dbg_active}, 32'd1);
        // R1: in debug, interrupt index 3 goes to tvec, breakpoint to entry
        do_trap(32'h8000_0003, 32'h404, 32'h9, 1, "R1");
        chk("R1", "irq3 to tvec", redirect_pc, TVEC);
        do_trap(32'h0000_0003, 32'h408, 32'h0, 1, "R1");
        chk("R1", "brk to entry", redirect_pc, ENTRY);
        do_reset();

        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [31:0] c;
            op = $urandom % 8;
            if (e_dbg && ($urandom % 4) == 0) begin
                do_reset();
            end else if (op < 4) begin
                case ($urandom % 4)
                    0: c = 32'h3;
                    1: c = $urandom;
                    default: c = {$urandom_range(1, 0) == 1, 27'd0, 4'($urandom)};
                endcase
                do_trap(c, $urandom, $urandom, ($urandom % 3) == 0, "");
            end else if (op < 7) begin
                logic [2:0] s;
                logic [31:0] d;
                s = 3'($urandom % 8);
                d = $urandom;
                if (s == 3'd5) d = {30'd0, 2'($urandom)};
                do_cfg(s, d);
            end else begin
                do_resv();
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule